// File: doc/BRIEF.md
# Volts-per-Hertz Profile and Frequency Ramp Controller

This block sits in front of the modulator of an induction motor inverter and turns an operator setpoint into two commands: the applied stator frequency and the voltage amplitude that goes with it. The applied frequency never jumps. On each 1 ms tick the block moves it toward the wanted value at a fixed rate. That rate comes from an acceleration-time setting, defined as the time to go from standstill to the 50 Hz rated frequency. A stop command drives the wanted value to zero, so the motor slows down at the same rate.

The voltage amplitude follows the applied frequency through one of four volts-per-hertz curves:

- The plain curve is proportional up to rated frequency.
- The other three hold a fixed low-frequency voltage floor up to a knee. Each uses a larger floor and a later knee than the one before it, and above the knee it follows the proportional law.
- Above rated frequency every curve stays at full voltage.

The amplitude is given as a fraction of the 220 V full scale, from 0 to 1023, and the modulator uses it directly as its modulation depth.

The ramp is run by a four-state machine:

- IDLE: standing still at 0 Hz.
- ACCEL: raising the frequency.
- DECEL: lowering the frequency.
- HOLD: sitting at a non-zero frequency that equals the wanted value.

The transitions are:

- IDLE goes to ACCEL when the wanted value rises above zero.
- ACCEL goes to HOLD when the target is reached, or to DECEL when the target drops below the present frequency.
- DECEL goes to ACCEL when the target rises above the present frequency. When the target is reached it goes to HOLD, or to IDLE if that target is 0 Hz.
- HOLD goes to ACCEL or DECEL when the target moves.

Each acceleration or deceleration interval is timed by a fractional accumulator. Every tick adds 50 to it, and one hertz is stepped each time it reaches the set time in ticks. Because the threshold is a multiple of 50 and the remainder is kept, the ramp runs exactly 20 ticks per hertz per second of setting and does not drift.

Top module: `vf_ramp_ctrl`

## Requirements
- R1: While reset is held and directly after it, freq_hz reads 0 and volt_cmd reads 0.
- R2: accel_sel selects the acceleration time as follows. Codes 0 to 8 select 1 s to 9 s in 1 s steps (code+1). Codes 9 to 19 select 10 s to 60 s in 5 s steps (10+5*(code-9)). Codes 20 to 31 select 60 s.
- R3: With T seconds selected and tick_1ms high, freq_hz moves by exactly one hertz every 20*T ticks, so 0 to 50 Hz takes exactly 1000*T ticks. It never moves by more than one hertz in a cycle.
- R4: The ramp target is tgt_hz clamped to 60. Once freq_hz equals the target it stays there, and it never exceeds 60.
- R5: When run is low the target is 0 Hz, and freq_hz falls at the same 20*T ticks per hertz until it reaches 0.
- R6: In a cycle with tick_1ms low, freq_hz does not change.
- R7: For curve_sel 0, and for any curve above its knee, a frequency f from 1 to 50 Hz gives volt_cmd = floor((f*1023+25)/50), which is 1023 at 50 Hz.
- R8: For f from 51 to 60 Hz, volt_cmd is 1023 on every curve.
- R9: The low-frequency floors are as follows. curve_sel 1 gives 100 for 1 to 5 Hz. curve_sel 2 gives 160 for 1 to 8 Hz. curve_sel 3 gives 200 for 1 to 10 Hz. Each floor is a 220 V-scaled code for 21.5 V, 34.5 V and 43 V respectively.
- R10: When freq_hz is 0, volt_cmd is 0 on every curve.
- R11: volt_cmd is registered. It reflects the freq_hz and curve_sel of the previous cycle, one clock after either changes.
- R12: A reversal of ramp direction clears the partial accumulation. The first step in the new direction comes a full 20*T ticks after the reversal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | Ramp time base, one pulse per millisecond |
| run | input | 1 | High to run toward tgt_hz, low to ramp down to stop |
| tgt_hz | input | 7 | Wanted frequency in hertz (clamped to 60) |
| curve_sel | input | 2 | Volts-per-hertz curve: 0 plain, 1 to 3 increasing boost |
| accel_sel | input | 5 | Acceleration time code |
| freq_hz | output | 7 | Present applied frequency in hertz |
| volt_cmd | output | 10 | Voltage amplitude, 1023 = 220 V |

## Verification
Two events can land on the same clock edge: a change of ramp target and the accumulator crossing its threshold or sitting partly filled.

The bench reverses the target while an up-ramp is half way through a one-hertz interval. It then checks that the first down step arrives a full interval later and not one cycle early. It also raises the target on the very cycle a step lands, and judges the next step by its exact edge count for each acceleration code.

A curve switch while the frequency holds is judged one edge later against the floor or proportional value.

// File: rtl/vf_pkg.sv
package vf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCEL,
        ST_DECEL,
        ST_HOLD
    } ramp_state_e;

    // Scale a voltage in millivolts to the amplitude code, rounded to nearest.
    function automatic int unsigned mv_to_code(int unsigned mv,
                                               int unsigned full_mv,
                                               int unsigned code_full);
        return (mv * code_full + full_mv / 2) / full_mv;
    endfunction

endpackage

// File: rtl/vf_accel_decode.sv
module vf_accel_decode #(
    parameter int unsigned CODE_W        = 5,
    parameter int unsigned LIM_W         = 17,
    parameter int unsigned TICKS_PER_S   = 1000,
    parameter int unsigned FINE_STEPS    = 9,
    parameter int unsigned COARSE_BASE_S = 10,
    parameter int unsigned COARSE_STEP_S = 5,
    parameter int unsigned T_MAX_S       = 60
) (
    input  logic [CODE_W-1:0] accel_sel,
    output logic [LIM_W-1:0]  limit
);
    localparam int unsigned COARSE_N = (T_MAX_S - COARSE_BASE_S) / COARSE_STEP_S + 1;

    int unsigned code_i;
    int unsigned secs;

    always_comb begin
        code_i = 32'(accel_sel);
        if (code_i < FINE_STEPS) begin
            secs = code_i + 1;
        end else if (code_i < FINE_STEPS + COARSE_N) begin
            secs = COARSE_BASE_S + COARSE_STEP_S * (code_i - FINE_STEPS);
        end else begin
            secs = T_MAX_S;
        end
        limit = LIM_W'(secs * TICKS_PER_S);
    end

endmodule

// File: rtl/vf_ramp_fsm.sv
module vf_ramp_fsm
    import vf_pkg::*;
#(
    parameter int unsigned FREQ_W  = 7,
    parameter int unsigned LIM_W   = 17,
    parameter int unsigned F_RATED = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [FREQ_W-1:0] tgt,
    input  logic [LIM_W-1:0]  limit,
    output logic [FREQ_W-1:0] freq,
    output ramp_state_e       state
);
    localparam logic [LIM_W-1:0] RATE = LIM_W'(F_RATED);

    ramp_state_e       state_nx;
    logic [LIM_W-1:0]  acc_q;
    logic [LIM_W-1:0]  acc_base;
    logic [LIM_W-1:0]  acc_sum;
    logic [LIM_W-1:0]  acc_rem;
    logic              go_up;
    logic              go_dn;
    logic              dir_kept;

    assign go_up    = tgt > freq;
    assign go_dn    = tgt < freq;
    assign dir_kept = (go_up && state == ST_ACCEL) || (go_dn && state == ST_DECEL);
    assign acc_base = dir_kept ? acc_q : '0;
    assign acc_sum  = acc_base + RATE;
    assign acc_rem  = acc_sum - limit;

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (go_up) state_nx = ST_ACCEL;
            end
            ST_ACCEL: begin
                if (go_dn)       state_nx = ST_DECEL;
                else if (!go_up) state_nx = ST_HOLD;
            end
            ST_DECEL: begin
                if (go_up)                  state_nx = ST_ACCEL;
                else if (!go_dn)            state_nx = (freq == '0) ? ST_IDLE : ST_HOLD;
            end
            ST_HOLD: begin
                if (go_up)      state_nx = ST_ACCEL;
                else if (go_dn) state_nx = ST_DECEL;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Frequency and accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq  <= '0;
            acc_q <= '0;
        end else if (!go_up && !go_dn) begin
            acc_q <= '0;
        end else if (tick) begin
            if (acc_sum >= limit) begin
                freq  <= go_up ? freq + 1'b1 : freq - 1'b1;
                acc_q <= (acc_rem >= limit) ? '0 : acc_rem;
            end else begin
                acc_q <= acc_sum;
            end
        end else begin
            acc_q <= acc_base;
        end
    end

endmodule

// File: rtl/vf_curve_map.sv
module vf_curve_map
    import vf_pkg::*;
#(
    parameter int unsigned FREQ_W     = 7,
    parameter int unsigned VOLT_W     = 10,
    parameter int unsigned F_RATED    = 50,
    parameter int unsigned V_RATED_MV = 220000,
    parameter int unsigned BOOST1_MV  = 21500,
    parameter int unsigned BOOST2_MV  = 34500,
    parameter int unsigned BOOST3_MV  = 43000,
    parameter int unsigned KNEE1_HZ   = 5,
    parameter int unsigned KNEE2_HZ   = 8,
    parameter int unsigned KNEE3_HZ   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] freq,
    input  logic [1:0]        curve_sel,
    output logic [VOLT_W-1:0] volt
);
    localparam int unsigned VFULL = (1 << VOLT_W) - 1;
    localparam int unsigned N_CURVE = 4;
    localparam int unsigned KNEE  [N_CURVE] = '{0, KNEE1_HZ, KNEE2_HZ, KNEE3_HZ};
    localparam int unsigned FLOOR [N_CURVE] = '{
        0,
        mv_to_code(BOOST1_MV, V_RATED_MV, VFULL),
        mv_to_code(BOOST2_MV, V_RATED_MV, VFULL),
        mv_to_code(BOOST3_MV, V_RATED_MV, VFULL)
    };

    logic [N_CURVE-1:0] in_boost;
    logic [VOLT_W-1:0]  floor_v [N_CURVE];
    logic [31:0]        lin_prod;
    logic [31:0]        lin_q32;
    logic [VOLT_W-1:0]  volt_nx;

    for (genvar g = 0; g < N_CURVE; g++) begin : g_curve
        assign in_boost[g] = (freq != '0) && (32'(freq) <= KNEE[g]);
        assign floor_v[g]  = VOLT_W'(FLOOR[g]);
    end

    assign lin_prod = 32'(freq) * VFULL;
    assign lin_q32  = (lin_prod + F_RATED / 2) / F_RATED;

    always_comb begin
        if (freq == '0) begin
            volt_nx = '0;
        end else if (32'(freq) >= F_RATED) begin
            volt_nx = VOLT_W'(VFULL);
        end else if (in_boost[curve_sel]) begin
            volt_nx = floor_v[curve_sel];
        end else begin
            volt_nx = lin_q32[VOLT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) volt <= '0;
        else        volt <= volt_nx;
    end

endmodule

// File: rtl/vf_ramp_ctrl.sv
module vf_ramp_ctrl
    import vf_pkg::*;
#(
    parameter int unsigned FREQ_W        = 7,
    parameter int unsigned VOLT_W        = 10,
    parameter int unsigned CODE_W        = 5,
    parameter int unsigned F_RATED       = 50,
    parameter int unsigned F_MAX         = 60,
    parameter int unsigned TICKS_PER_S   = 1000,
    parameter int unsigned FINE_STEPS    = 9,
    parameter int unsigned COARSE_BASE_S = 10,
    parameter int unsigned COARSE_STEP_S = 5,
    parameter int unsigned T_MAX_S       = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1ms,
    input  logic              run,
    input  logic [FREQ_W-1:0] tgt_hz,
    input  logic [1:0]        curve_sel,
    input  logic [CODE_W-1:0] accel_sel,
    output logic [FREQ_W-1:0] freq_hz,
    output logic [VOLT_W-1:0] volt_cmd
);
    localparam int unsigned LIM_W = $clog2(T_MAX_S * TICKS_PER_S + F_RATED + 1) + 1;
    localparam logic [FREQ_W-1:0] FMAX_V = FREQ_W'(F_MAX);

    logic [FREQ_W-1:0] tgt_eff;
    logic [LIM_W-1:0]  limit;
    ramp_state_e       state;

    assign tgt_eff = !run ? '0 : ((tgt_hz > FMAX_V) ? FMAX_V : tgt_hz);

    vf_accel_decode #(
        .CODE_W(CODE_W), .LIM_W(LIM_W), .TICKS_PER_S(TICKS_PER_S),
        .FINE_STEPS(FINE_STEPS), .COARSE_BASE_S(COARSE_BASE_S),
        .COARSE_STEP_S(COARSE_STEP_S), .T_MAX_S(T_MAX_S)
    ) u_dec (
        .accel_sel(accel_sel),
        .limit(limit)
    );

    vf_ramp_fsm #(
        .FREQ_W(FREQ_W), .LIM_W(LIM_W), .F_RATED(F_RATED)
    ) u_ramp (
        .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .tgt(tgt_eff),
        .limit(limit), .freq(freq_hz), .state(state)
    );

    vf_curve_map #(
        .FREQ_W(FREQ_W), .VOLT_W(VOLT_W), .F_RATED(F_RATED)
    ) u_map (
        .clk(clk), .rst_n(rst_n), .freq(freq_hz),
        .curve_sel(curve_sel), .volt(volt_cmd)
    );

endmodule

// File: rtl/vf_ramp_chk.sv
module vf_ramp_chk #(
    parameter int unsigned FREQ_W  = 7,
    parameter int unsigned VOLT_W  = 10,
    parameter int unsigned F_RATED = 50,
    parameter int unsigned F_MAX   = 60
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1ms,
    input logic [FREQ_W-1:0] freq_hz,
    input logic [VOLT_W-1:0] volt_cmd
);
    localparam logic [VOLT_W-1:0] VFULL = '1;

    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (freq_hz == $past(freq_hz)) || (freq_hz == $past(freq_hz) + 1'b1)
                 || (freq_hz + 1'b1 == $past(freq_hz)));

    p_no_tick_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_1ms |=> $stable(freq_hz));

    p_fmax_r4: assert property (@(posedge clk) disable iff (!rst_n)
        32'(freq_hz) <= F_MAX);

    p_zero_volt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        freq_hz == '0 |=> volt_cmd == '0);

    p_flat_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        32'(freq_hz) > F_RATED |=> volt_cmd == VFULL);

    p_rated_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(freq_hz) == F_RATED |=> volt_cmd == VFULL);

endmodule

bind vf_ramp_ctrl vf_ramp_chk #(
    .FREQ_W(FREQ_W), .VOLT_W(VOLT_W), .F_RATED(F_RATED), .F_MAX(F_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms),
    .freq_hz(freq_hz), .volt_cmd(volt_cmd)
);

// File: tb/test_vf_ramp_ctrl.sv
module test_vf_ramp_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1ms = 1'b0;
    logic       run = 1'b0;
    logic [6:0] tgt_hz = '0;
    logic [1:0] curve_sel = '0;
    logic [4:0] accel_sel = '0;
    logic [6:0] freq_hz;
    logic [9:0] volt_cmd;

    int n_checks = 0;
    int n_errors = 0;
    int cur = 0;

    typedef struct {
        string tag;
        int    ef;
        int    ev;
        bit    cv;
    } item_t;
    item_t sbq[$];

    always #2.5 clk = ~clk;

    vf_ramp_ctrl i_vf_ramp_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .run(run),
        .tgt_hz(tgt_hz), .curve_sel(curve_sel), .accel_sel(accel_sel),
        .freq_hz(freq_hz), .volt_cmd(volt_cmd)
    );

    function automatic int exp_volt(int f, int c);
        if (f == 0) return 0;
        if (f >= 50) return 1023;
        if (c == 1 && f <= 5) return 100;
        if (c == 2 && f <= 8) return 160;
        if (c == 3 && f <= 10) return 200;
        return (f * 1023 + 25) / 50;
    endfunction

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(string tag, int ef, int ev, bit cv);
        item_t it;
        it.tag = tag; it.ef = ef; it.ev = ev; it.cv = cv;
        sbq.push_back(it);
    endtask

    // Monitor: compares queued expectations with the outputs
    initial begin
        item_t it;
        forever begin
            wait (sbq.size() > 0);
            #1;
            while (sbq.size() > 0) begin
                it = sbq.pop_front();
                n_checks++;
                if (32'(freq_hz) != it.ef) begin
                    n_errors++;
                    $display("FAIL %s freq_hz actual=%0d expected=%0d", it.tag, freq_hz, it.ef);
                end
                if (it.cv) begin
                    n_checks++;
                    if (32'(volt_cmd) != it.ev) begin
                        n_errors++;
                        $display("FAIL %s volt_cmd actual=%0d expected=%0d", it.tag, volt_cmd, it.ev);
                    end
                end
            end
        end
    end

    task automatic goto_hz(int f);
        int d;
        d = (f > cur) ? f - cur : cur - f;
        tgt_hz = 7'(f);
        step(d * 20 + 1);
        cur = f;
        expect_out("R4 reach target", f, 0, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        int codes [5] = '{8, 9, 10, 19, 25};
        int secs  [5] = '{9, 10, 15, 60, 60};
        int flist [10] = '{55, 30, 11, 10, 9, 8, 6, 5, 3, 1};

        tick_1ms = 1'b1;
        step(3);
        expect_out("R1 in reset", 0, 0, 1'b1);
        rst_n = 1'b1;
        run = 1'b1;
        step(5);
        expect_out("R1 after reset", 0, 0, 1'b1);

        // R3 / R11 / R7: ramp 0 -> 50 Hz with 1 s
        tgt_hz = 7'd50;
        step(19);
        expect_out("R3 before first step", 0, 0, 1'b1);
        step(1);
        expect_out("R11 volt lags freq", 1, 0, 1'b1);
        step(1);
        expect_out("R7 volt at 1 Hz", 1, 20, 1'b1);
        step(978);
        expect_out("R3 edge 999", 49, 0, 1'b0);
        step(1);
        expect_out("R3 50 Hz at 1000 ticks", 50, 0, 1'b0);
        step(1);
        expect_out("R7 full at rated", 50, 1023, 1'b1);
        cur = 50;

        tgt_hz = 7'd60;
        step(200);
        expect_out("R3 reach 60", 60, 0, 1'b0);
        step(1);
        expect_out("R8 flat top", 60, 1023, 1'b1);
        cur = 60;
        tgt_hz = 7'd100;
        step(100);
        expect_out("R4 clamp at 60", 60, 1023, 1'b1);

        // R9 / R7 / R8: curve sweep at held frequencies
        foreach (flist[i]) begin
            goto_hz(flist[i]);
            for (int c = 0; c < 4; c++) begin
                curve_sel = 2'(c);
                step(1);
                expect_out("R9 curve value", flist[i], exp_volt(flist[i], c), 1'b1);
            end
        end
        curve_sel = 2'd0;

        // R12: reversal mid-interval
        tgt_hz = 7'd20;
        step(30);
        expect_out("R12 partial up", 2, 0, 1'b0);
        tgt_hz = 7'd0;
        step(19);
        expect_out("R12 no early step", 2, 0, 1'b0);
        step(1);
        expect_out("R12 full interval", 1, 0, 1'b0);
        step(20);
        step(1);
        expect_out("R10 zero at 0 Hz", 0, 0, 1'b1);
        cur = 0;

        // R5: stop ramps down
        goto_hz(30);
        run = 1'b0;
        step(19);
        expect_out("R5 stop interval", 30, 0, 1'b0);
        step(1);
        expect_out("R5 first down step", 29, 0, 1'b0);
        step(580);
        expect_out("R5 reach 0", 0, 0, 1'b0);
        curve_sel = 2'd3;
        step(1);
        expect_out("R10 zero on boost curve", 0, 0, 1'b1);
        cur = 0;
        curve_sel = 2'd0;
        run = 1'b1;

        // R2: acceleration code decode
        foreach (codes[i]) begin
            accel_sel = 5'(codes[i]);
            tgt_hz = 7'(cur + 1);
            step(20 * secs[i] - 1);
            expect_out("R2 before step", cur, 0, 1'b0);
            step(1);
            expect_out("R2 step time", cur + 1, 0, 1'b0);
            cur++;
        end

        // R6: no tick no move
        tick_1ms = 1'b0;
        accel_sel = 5'd0;
        tgt_hz = 7'(cur + 10);
        step(300);
        expect_out("R6 frozen", cur, 0, 1'b0);
        tick_1ms = 1'b1;
        step(19);
        expect_out("R6 resumed wait", cur, 0, 1'b0);
        step(1);
        expect_out("R6 resumed step", cur + 1, 0, 1'b0);

        #2;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule